// File: doc/BRIEF.md
# Dual-Compare Timer Output Generator

The block is a small free-running up-counter with two compare registers, A and B, that drive one shared timer output pin. On each clock where the count-enable tick is high, the counter advances by one. A channel matches when the tick is high and the counter equals that channel's compare value. Each channel has a 2-bit action code in the control register, and the code sets what a match does to the pin. When both channels match in the same cycle, a fixed priority settles the result.

Software reaches the counter, both compare registers and the control register through a plain write strobe and a combinational read port. The control register also has one bit that makes a compare-A match restart the count from zero. If both action codes are zero, the generator is switched off and the pin is held low.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the counter reads 0, both compare registers read all ones in the low CNT_W bits, the control register reads 0x10 and the pin is 0.
- R2: Each cycle with tick high, no counter write and no clear, the counter increases by one and wraps from its maximum value to 0.
- R3: A channel matches only in a cycle with tick high and counter equal to its compare value. With no match, the pin keeps its value.
- R4: Control bits [1:0] are the action for compare A and bits [3:2] the action for compare B. The codes are 00 keep, 01 drive low, 10 drive high, 11 invert. The pin takes the new level in the cycle after the match cycle.
- R5: When both channels match in one cycle, invert beats drive-high and drive-high beats drive-low. A keep code on one channel leaves the other channel's action in force.
- R6: While control bits [3:0] are all 0 the pin is low, and compare matches have no effect on it.
- R7: Control bit 4 always reads 1 and ignores writes. Bits 7:6 read 0.
- R8: With control bit 5 set, a compare-A match loads the counter with 0 in place of the increment.
- R9: A write takes effect at the next clock edge. A counter write in the same cycle as a tick or a clear wins over both.
- R10: Address 0 selects the counter, 1 compare A, 2 compare B and 3 control. Read data follows the address in the same cycle and is zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count-enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| tmr_out | output | 1 | Timer output pin |

## Verification
The bench builds the block with CNT_W = 4. With this width a wrap takes only sixteen ticks, and the full counter sequence is checked step by step. All sixteen control codes are tried with both channels matching in the same tick, each from a low and a high starting pin level. This covers every single-channel action, every priority pairing and the disabled code. Targeted cases cover match-free ticks, a match on one channel alone, clear on compare A, and a counter write in the same cycle as a tick.

// File: rtl/dct_pkg.sv
// Package: shared constants and types for the dual-compare timer.
// Assumes an 8-bit register data path and counters no wider than that.
package dct_pkg;
    localparam int REG_W        = 8;
    localparam int ADDR_W       = 2;
    localparam int NUM_CH       = 2;
    localparam int CTRL_RSV_BIT = 4;
    localparam int CTRL_CLR_BIT = 5;

    localparam logic [ADDR_W-1:0] ADR_CNT  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CMPA = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CMPB = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd3;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_INV  = 2'b11
    } act_e;
endpackage

// File: rtl/dct_regs.sv
// Module: dct_regs
// Holds both compare registers and the control fields. Writes land at the
// next clock edge. Assumes CNT_W <= REG_W.
module dct_regs
    import dct_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [CNT_W-1:0]  cmp_a,
    output logic [CNT_W-1:0]  cmp_b,
    output act_e              act_a,
    output act_e              act_b,
    output logic              clr_on_a,
    output logic [REG_W-1:0]  ctrl_rd
);
    logic [3:0] osel_q;
    logic       clr_q;
    logic       wdata_unused;

    // Reserved and upper write bits are discarded.
    assign wdata_unused = ^{wdata[REG_W-1:CTRL_CLR_BIT+1], wdata[CTRL_RSV_BIT]};

    // Compare register A update.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cmp_a <= '1;
        else if (wr_en && addr == ADR_CMPA)  cmp_a <= wdata[CNT_W-1:0];
    end

    // Compare register B update.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cmp_b <= '1;
        else if (wr_en && addr == ADR_CMPB)  cmp_b <= wdata[CNT_W-1:0];
    end

    // Control field update; the reserved bit has no storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osel_q <= '0;
            clr_q  <= 1'b0;
        end else if (wr_en && addr == ADR_CTRL) begin
            osel_q <= wdata[3:0];
            clr_q  <= wdata[CTRL_CLR_BIT];
        end
    end

    // Split the output-select field into per-channel action codes.
    always_comb begin
        act_a    = act_e'(osel_q[1:0]);
        act_b    = act_e'(osel_q[3:2]);
        clr_on_a = clr_q;
        ctrl_rd  = '0;
        ctrl_rd[3:0]          = osel_q;
        ctrl_rd[CTRL_RSV_BIT] = 1'b1;
        ctrl_rd[CTRL_CLR_BIT] = clr_q;
    end

    assert_cmpa_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADR_CMPA) |=> $stable(cmp_a));
    assert_cmpb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADR_CMPB) |=> $stable(cmp_b));
endmodule

// File: rtl/dct_counter.sv
// Module: dct_counter
// Up-counter of CNT_W bits. Priority is load, then clear on compare A,
// then tick increment with natural wrap.
module dct_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    // Counter state with load > clear > increment.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (ld)   cnt <= ld_val;
        else if (clr)  cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && !clr) |=> cnt == CNT_W'($past(cnt) + 1'b1));
    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> cnt == $past(ld_val));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ld) |=> cnt == '0);
endmodule

// File: rtl/dct_outgen.sv
// Module: dct_outgen
// Detects the two compare matches, resolves their actions with the fixed
// priority invert > high > low, and holds the output flop. Both codes at
// keep disable the pin (held low).
module dct_outgen
    import dct_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  act_e             act_a,
    input  act_e             act_b,
    output logic             hit_a,
    output logic             tmr_out
);
    logic [CNT_W-1:0] cmp [NUM_CH];
    act_e             act [NUM_CH];
    logic [NUM_CH-1:0] hit, want_inv, want_high, want_low;
    logic out_q, out_d, enabled;

    assign cmp[0] = cmp_a;
    assign cmp[1] = cmp_b;
    assign act[0] = act_a;
    assign act[1] = act_b;

    // Per-channel match and action request decode.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign hit[ch]       = tick && (cnt == cmp[ch]);
        assign want_inv[ch]  = hit[ch] && (act[ch] == ACT_INV);
        assign want_high[ch] = hit[ch] && (act[ch] == ACT_HIGH);
        assign want_low[ch]  = hit[ch] && (act[ch] == ACT_LOW);
    end

    assign hit_a   = hit[0];
    assign enabled = (act_a != ACT_KEEP) || (act_b != ACT_KEEP);

    // Resolve simultaneous requests by fixed priority.
    always_comb begin
        if (|want_inv)       out_d = ~out_q;
        else if (|want_high) out_d = 1'b1;
        else if (|want_low)  out_d = 1'b0;
        else                 out_d = out_q;
    end

    // Output flop.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    assign tmr_out = enabled && out_q;

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(|hit) |=> $stable(out_q));
    assert_inv_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_a && act_a == ACT_INV) || (hit[1] && act_b == ACT_INV))
        |=> out_q != $past(out_q));
    assert_disabled_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_a == ACT_KEEP && act_b == ACT_KEEP) |=> $stable(out_q));
endmodule

// File: rtl/dual_cmp_timer.sv
// Module: dual_cmp_timer (top)
// Dual-compare timer with one shared output pin and a simple register port.
// Assumes 1 <= CNT_W <= 8 and a synchronous active-low reset.
module dual_cmp_timer
    import dct_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              tmr_out
);
    logic [CNT_W-1:0] cnt, cmp_a, cmp_b;
    act_e             act_a, act_b;
    logic             clr_on_a, hit_a, cnt_ld;
    logic [REG_W-1:0] ctrl_rd;

    assign cnt_ld = wr_en && (addr == ADR_CNT);

    dct_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .act_a(act_a), .act_b(act_b),
        .clr_on_a(clr_on_a), .ctrl_rd(ctrl_rd)
    );

    dct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ld(cnt_ld),
        .ld_val(wdata[CNT_W-1:0]), .clr(hit_a && clr_on_a), .cnt(cnt)
    );

    dct_outgen #(.CNT_W(CNT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .act_a(act_a), .act_b(act_b),
        .hit_a(hit_a), .tmr_out(tmr_out)
    );

    // Combinational register read mux.
    always_comb begin
        case (addr)
            ADR_CNT:  rdata = REG_W'(cnt);
            ADR_CMPA: rdata = REG_W'(cmp_a);
            ADR_CMPB: rdata = REG_W'(cmp_b);
            default:  rdata = ctrl_rd;
        endcase
    end

    assert_rsv_reads_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADR_CTRL) |-> rdata[CTRL_RSV_BIT]);
    assert_disabled_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_a == ACT_KEEP && act_b == ACT_KEEP) |-> !tmr_out);
endmodule

// File: tb/tb_dual_cmp_timer.sv
module tb_dual_cmp_timer;
    localparam int W = 4;
    localparam int MAXV = (1 << W) - 1;

    logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
    logic [1:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic tmr_out;
    int checks = 0, failures = 0;
    bit done = 0;

    dual_cmp_timer #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tmr_out(tmr_out)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        addr = a; #1; v = rdata;
    endtask

    task automatic tick1();
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
    endtask

    // Expected pin after a same-tick match on both channels.
    function automatic bit expect_pin(input bit [3:0] os, input bit prev);
        bit [1:0] a = os[1:0], b = os[3:2];
        if (os == 0) return 0;
        if (a == 3 || b == 3) return !prev;
        if (a == 2 || b == 2) return 1;
        if (a == 1 || b == 1) return 0;
        return prev;
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(0, v); check("R1 cnt", v, 0);
        rd(1, v); check("R1 cmpA", v, MAXV);
        rd(2, v); check("R1 cmpB", v, MAXV);
        rd(3, v); check("R1 ctrl", v, 8'h10);
        check("R1 pin", tmr_out, 0);

        // R7 reserved bit, R10 map
        wr(3, 8'hFF); rd(3, v); check("R7 ctrl all ones", v, 8'h3F);
        wr(3, 8'h00); rd(3, v); check("R7 ctrl zero", v, 8'h10);
        wr(1, 8'hA7); rd(1, v); check("R10 cmpA zero-ext", v, 7);
        wr(2, 8'h5C); rd(2, v); check("R10 cmpB zero-ext", v, 12);

        // R2 increment and wrap
        wr(0, 0);
        for (int i = 1; i <= 2 * (MAXV + 1); i++) begin
            tick1(); rd(0, v); check("R2 count", v, i % (MAXV + 1));
        end

        // R4/R5/R6 exhaustive: all codes, both start levels, both channels hit
        wr(1, 5); wr(2, 5);
        for (int os = 0; os < 16; os++) begin
            for (int lv = 0; lv < 2; lv++) begin
                wr(0, 5); wr(3, lv ? 8'h02 : 8'h01); tick1();
                check("R4 set start level", tmr_out, lv);
                wr(0, 5); wr(3, 8'(os)); tick1();
                check(os == 0 ? "R6 disabled" : "R5 priority", tmr_out,
                      expect_pin(4'(os), bit'(lv)));
            end
        end

        // R3 no tick, and tick without equality
        wr(0, 5); wr(3, 8'h03); tick1();
        check("R4 invert from low", tmr_out, 1);
        wr(0, 5); repeat (6) @(negedge clk);
        check("R3 no tick no change", tmr_out, 1);
        wr(0, 6); tick1();
        check("R3 unequal no change", tmr_out, 1);

        // R6 disable drives low at once, matches ignored
        wr(3, 8'h00); #1; check("R6 low when disabled", tmr_out, 0);
        wr(0, 5); tick1(); check("R6 match ignored", tmr_out, 0);

        // R4 only A matches: B invert not applied
        wr(1, 3); wr(2, 9);
        wr(0, 3); wr(3, 8'h01); tick1(); check("R4 A low", tmr_out, 0);
        wr(0, 3); wr(3, 8'h0E); tick1(); check("R4 A alone high", tmr_out, 1);
        wr(0, 9); wr(3, 8'h08); tick1(); check("R4 B alone high", tmr_out, 1);
        wr(0, 9); wr(3, 8'h04); tick1(); check("R4 B alone low", tmr_out, 0);

        // R8 clear on compare A
        wr(1, 6);
        wr(0, 6); wr(3, 8'h20); tick1(); rd(0, v); check("R8 clear on A", v, 0);
        wr(0, 6); wr(3, 8'h00); tick1(); rd(0, v); check("R8 no clear when off", v, 7);

        // R9 counter write beats tick and clear
        wr(3, 8'h20); wr(0, 6);
        @(negedge clk); wr_en = 1; addr = 0; wdata = 11; tick = 1;
        @(negedge clk); wr_en = 0; tick = 0;
        rd(0, v); check("R9 write beats clear", v, 11);
        @(negedge clk); wr_en = 1; addr = 0; wdata = 2; tick = 1;
        @(negedge clk); wr_en = 0; tick = 0;
        rd(0, v); check("R9 write beats tick", v, 2);
        wr(0, MAXV); wr(3, 0); tick1(); rd(0, v); check("R2 wrap max", v, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule